// File: doc/BRIEF.md
# Configuration Parameter Update Controller

This block holds the small set of settings that steer a remote reconfiguration: a status tag, a page address, a watchdog limit, a watchdog enable and an operating-mode flag. It keeps them in two banks. The active bank holds the settings now in force. The staging bank collects values for the next reconfiguration. Software moves parameters through a pulse-driven read/write handshake. A busy flag covers each transfer, and a bank-select input picks which bank a read returns.

A reconfiguration request copies the staging bank into the active bank after a fixed stub latency. This stands in for the real device restart. A user watchdog runs from the active settings and raises a timeout pulse. A falling edge on a clear input restarts the watchdog at any time, whether or not the handshake is busy. When the active bank says application mode, the block refuses parameter writes.

Top module: `cfg_update_ctrl`

## Requirements
- R1: While reset (active high, asynchronous) is high and after it is released, busy, read data, the reconfiguration pulse and the timeout pulse are low or zero, and every field of both banks is zero (factory mode, watchdog off).
- R2: A rising edge on the read or write request while idle is accepted. Busy is then high for exactly OP_LAT cycles, starting with the cycle after the accepting edge. A request held high starts no second operation.
- R3: Read data is zero while busy is high, including during writes and reconfiguration. After a read completes, the value is held until the next accepted operation.
- R4: Write data is captured on the accepting edge. Changes to the data input while busy is high have no effect on the stored value.
- R5: With bank select at 1, a read returns the active bank. With bank select at 0, it returns the staging bank. Writes go only to the staging bank. The active bank changes only when a reconfiguration completes, and it then takes the staging bank's contents.
- R6: The selector codes are: 0 = status (5 bits), 1 = watchdog limit (WDOG_W = 12 bits), 2 = watchdog enable (bit 0), 3 = page address (32 bits), 4 = mode (bit 0, 1 = application). Each field sits in the low-order bits and the upper bits read as zero. Codes 5 to 7 read as zero, and writes to them store nothing.
- R7: When the active mode bit is 1, a write request raises no busy and leaves the staging bank unchanged. Reads still work.
- R8: A reconfiguration request is ignored while busy is high. When accepted while idle, it holds busy for RCFG_LAT cycles. In the cycle busy falls, the active bank holds the staging values and the reconfiguration output pulses for one cycle.
- R9: If a reconfiguration request and a read or write request arrive in the same idle cycle, the reconfiguration is taken and the other request is dropped.
- R10: While the active watchdog enable is 1, the counter starts from zero when a reconfiguration completes and advances once per cycle. One cycle after it equals the limit T, a one-cycle timeout pulse appears and counting restarts, giving a period of T+1 cycles.
- R11: A falling edge on the watchdog clear restarts the counter from zero even while busy is high. If the edge lands in the same cycle as a timeout, the clear wins and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| rd_req_i | input | 1 | Parameter read request (pulse) |
| wr_req_i | input | 1 | Parameter write request (pulse) |
| sel_i | input | 3 | Parameter selector |
| bank_ctl_i | input | 1 | Read bank select: 1 active, 0 staging |
| wdata_i | input | 32 | Parameter write data |
| reconf_req_i | input | 1 | Reconfiguration request |
| wdog_clr_i | input | 1 | Watchdog clear, acts on falling edge |
| busy_o | output | 1 | Operation in progress |
| rdata_o | output | 32 | Parameter read data |
| reconf_o | output | 1 | One-cycle pulse when reconfiguration completes |
| wdog_tmo_o | output | 1 | One-cycle watchdog timeout pulse |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a watchdog clear edge and a timeout. The bench lets a pulse mark counter zero, waits exactly T cycles, and drops the clear so that its falling edge meets the counter at its limit. It then checks that no pulse follows and that the next one comes a full period later. The second pair is a reconfiguration request arriving in the same idle cycle as a write. The bench checks that busy lasts the reconfiguration length and that the staging bank still holds its old page value.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;

    localparam int DATA_W = 32;
    localparam int SEL_W  = 3;
    localparam int STAT_W = 5;
    localparam int WDOG_W = 12;

    localparam logic [SEL_W-1:0] P_STATUS = 3'd0;
    localparam logic [SEL_W-1:0] P_LIMIT  = 3'd1;
    localparam logic [SEL_W-1:0] P_WDEN   = 3'd2;
    localparam logic [SEL_W-1:0] P_PAGE   = 3'd3;
    localparam logic [SEL_W-1:0] P_MODE   = 3'd4;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [WDOG_W-1:0] limit;
        logic              wd_en;
        logic [DATA_W-1:0] page;
        logic              app_mode;
    } bank_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_RCFG
    } seq_st_e;

    // Zero-extended view of one field.
    function automatic word_t bank_get(bank_t b, sel_t s);
        word_t r;
        r = '0;
        case (s)
            P_STATUS: r[STAT_W-1:0] = b.status;
            P_LIMIT:  r[WDOG_W-1:0] = b.limit;
            P_WDEN:   r[0]          = b.wd_en;
            P_PAGE:   r             = b.page;
            P_MODE:   r[0]          = b.app_mode;
            default:  r             = '0;
        endcase
        return r;
    endfunction

    // Bank with one field replaced by the low-order bits of v.
    function automatic bank_t bank_put(bank_t b, sel_t s, word_t v);
        bank_t r;
        r = b;
        case (s)
            P_STATUS: r.status   = v[STAT_W-1:0];
            P_LIMIT:  r.limit    = v[WDOG_W-1:0];
            P_WDEN:   r.wd_en    = v[0];
            P_PAGE:   r.page     = v;
            P_MODE:   r.app_mode = v[0];
            default:  r          = b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfgu_bank.sv
module cfgu_bank
    import cfgu_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  wr_en_i,
    input  sel_t  wr_sel_i,
    input  word_t wr_data_i,
    input  logic  load_en_i,
    input  bank_t load_val_i,
    output bank_t val_o
);

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (load_en_i) begin
            bank_d = load_val_i;
        end else if (wr_en_i) begin
            bank_d = bank_put(bank_q, wr_sel_i, wr_data_i);
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign val_o = bank_q;

endmodule

// File: rtl/cfgu_wdog.sv
module cfgu_wdog
    import cfgu_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [WDOG_W-1:0] limit_i,
    input  logic              restart_i,
    input  logic              clr_i,
    output logic              tmo_o
);

    typedef struct packed {
        logic [WDOG_W-1:0] cnt;
        logic              clr_prev;
        logic              tmo;
    } wd_s;

    wd_s wd_d, wd_q;
    logic clr_fall;

    assign clr_fall = wd_q.clr_prev & ~clr_i;

    always_comb begin
        wd_d          = wd_q;
        wd_d.clr_prev = clr_i;
        wd_d.tmo      = 1'b0;
        if (restart_i || clr_fall) begin
            wd_d.cnt = '0;
        end else if (!en_i) begin
            wd_d.cnt = '0;
        end else if (wd_q.cnt == limit_i) begin
            wd_d.cnt = '0;
            wd_d.tmo = 1'b1;
        end else begin
            wd_d.cnt = wd_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign tmo_o = wd_q.tmo;

endmodule

// File: rtl/cfgu_seq.sv
module cfgu_seq
    import cfgu_pkg::*;
#(
    parameter int OP_LAT   = 4,
    parameter int RCFG_LAT = 6
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  rd_req_i,
    input  logic  wr_req_i,
    input  logic  reconf_req_i,
    input  sel_t  sel_i,
    input  logic  bank_ctl_i,
    input  word_t wdata_i,
    input  logic  app_mode_i,
    input  bank_t ctl_val_i,
    input  bank_t upd_val_i,
    output logic  upd_wr_o,
    output sel_t  upd_sel_o,
    output word_t upd_data_o,
    output logic  rcfg_fire_o,
    output logic  busy_o,
    output word_t rdata_o,
    output logic  reconf_o
);

    localparam int MAX_LAT = (OP_LAT > RCFG_LAT) ? OP_LAT : RCFG_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic              rd_prev;
        logic              wr_prev;
        sel_t              sel;
        logic              bank;
        word_t             data;
        word_t             rdata;
        logic              done;
    } seq_s;

    seq_s sq_d, sq_q;
    logic rd_go, wr_go;

    assign rd_go = rd_req_i & ~sq_q.rd_prev;
    assign wr_go = wr_req_i & ~sq_q.wr_prev & ~app_mode_i;

    always_comb begin
        sq_d         = sq_q;
        sq_d.rd_prev = rd_req_i;
        sq_d.wr_prev = wr_req_i;
        sq_d.done    = 1'b0;
        upd_wr_o     = 1'b0;
        rcfg_fire_o  = 1'b0;
        case (sq_q.st)
            ST_IDLE: begin
                if (reconf_req_i) begin
                    sq_d.st    = ST_RCFG;
                    sq_d.cnt   = CNT_W'(RCFG_LAT - 1);
                    sq_d.rdata = '0;
                end else if (wr_go) begin
                    sq_d.st    = ST_WRITE;
                    sq_d.cnt   = CNT_W'(OP_LAT - 1);
                    sq_d.sel   = sel_i;
                    sq_d.data  = wdata_i;
                    sq_d.rdata = '0;
                end else if (rd_go) begin
                    sq_d.st    = ST_READ;
                    sq_d.cnt   = CNT_W'(OP_LAT - 1);
                    sq_d.sel   = sel_i;
                    sq_d.bank  = bank_ctl_i;
                    sq_d.rdata = '0;
                end
            end
            ST_READ: begin
                if (sq_q.cnt == '0) begin
                    sq_d.st    = ST_IDLE;
                    sq_d.rdata = sq_q.bank ? bank_get(ctl_val_i, sq_q.sel)
                                           : bank_get(upd_val_i, sq_q.sel);
                end else begin
                    sq_d.cnt = sq_q.cnt - 1'b1;
                end
            end
            ST_WRITE: begin
                if (sq_q.cnt == '0) begin
                    sq_d.st  = ST_IDLE;
                    upd_wr_o = 1'b1;
                end else begin
                    sq_d.cnt = sq_q.cnt - 1'b1;
                end
            end
            ST_RCFG: begin
                if (sq_q.cnt == '0) begin
                    sq_d.st     = ST_IDLE;
                    sq_d.done   = 1'b1;
                    rcfg_fire_o = 1'b1;
                end else begin
                    sq_d.cnt = sq_q.cnt - 1'b1;
                end
            end
            default: sq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            sq_q    <= '0;
            sq_q.st <= ST_IDLE;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign upd_sel_o  = sq_q.sel;
    assign upd_data_o = sq_q.data;
    assign busy_o     = (sq_q.st != ST_IDLE);
    assign rdata_o    = sq_q.rdata;
    assign reconf_o   = sq_q.done;

endmodule

// File: rtl/cfg_update_ctrl.sv
module cfg_update_ctrl
    import cfgu_pkg::*;
#(
    parameter int OP_LAT   = 4,
    parameter int RCFG_LAT = 6
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        rd_req_i,
    input  logic                        wr_req_i,
    input  logic [cfgu_pkg::SEL_W-1:0]  sel_i,
    input  logic                        bank_ctl_i,
    input  logic [cfgu_pkg::DATA_W-1:0] wdata_i,
    input  logic                        reconf_req_i,
    input  logic                        wdog_clr_i,
    output logic                        busy_o,
    output logic [cfgu_pkg::DATA_W-1:0] rdata_o,
    output logic                        reconf_o,
    output logic                        wdog_tmo_o
);

    localparam int CTL = 0;
    localparam int UPD = 1;

    bank_t bank_val [2];
    logic  upd_wr;
    sel_t  upd_sel;
    word_t upd_data;
    logic  rcfg_fire;
    logic  app_mode;

    assign app_mode = bank_val[CTL].app_mode;

    for (genvar gi = 0; gi < 2; gi++) begin : g_bank
        cfgu_bank u_bank (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .wr_en_i    ((gi == UPD) ? upd_wr : 1'b0),
            .wr_sel_i   (upd_sel),
            .wr_data_i  (upd_data),
            .load_en_i  ((gi == CTL) ? rcfg_fire : 1'b0),
            .load_val_i (bank_val[UPD]),
            .val_o      (bank_val[gi])
        );
    end

    cfgu_seq #(
        .OP_LAT   (OP_LAT),
        .RCFG_LAT (RCFG_LAT)
    ) u_seq (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .rd_req_i     (rd_req_i),
        .wr_req_i     (wr_req_i),
        .reconf_req_i (reconf_req_i),
        .sel_i        (sel_i),
        .bank_ctl_i   (bank_ctl_i),
        .wdata_i      (wdata_i),
        .app_mode_i   (app_mode),
        .ctl_val_i    (bank_val[CTL]),
        .upd_val_i    (bank_val[UPD]),
        .upd_wr_o     (upd_wr),
        .upd_sel_o    (upd_sel),
        .upd_data_o   (upd_data),
        .rcfg_fire_o  (rcfg_fire),
        .busy_o       (busy_o),
        .rdata_o      (rdata_o),
        .reconf_o     (reconf_o)
    );

    cfgu_wdog u_wdog (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (bank_val[CTL].wd_en),
        .limit_i   (bank_val[CTL].limit),
        .restart_i (rcfg_fire),
        .clr_i     (wdog_clr_i),
        .tmo_o     (wdog_tmo_o)
    );

endmodule

// File: rtl/cfgu_chk.sv
module cfgu_chk #(
    parameter int OP_LAT   = 4,
    parameter int RCFG_LAT = 6
) (
    input logic        clk_i,
    input logic        rst_i,
    input logic        rd_req_i,
    input logic        wr_req_i,
    input logic        reconf_req_i,
    input logic        wdog_clr_i,
    input logic        app_mode_i,
    input logic        busy_o,
    input logic [31:0] rdata_o,
    input logic        reconf_o,
    input logic        wdog_tmo_o
);

    localparam int MAX_LAT = (OP_LAT > RCFG_LAT) ? OP_LAT : RCFG_LAT;

    logic [7:0] run_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
        end else begin
            run_q <= '0;
        end
    end

    AST_RD_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && rd_req_i && !$past(rd_req_i)) |=> busy_o); // R2

    AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q <= 8'(MAX_LAT))); // R2

    AST_RDATA_ZERO_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |-> (rdata_o == 32'd0)); // R3

    AST_APP_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && app_mode_i && wr_req_i && !rd_req_i && !reconf_req_i) |=> !busy_o); // R7

    AST_RCFG_AT_BUSY_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        reconf_o |-> (!busy_o && $past(busy_o))); // R8

    AST_CLR_BEATS_TMO: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(wdog_clr_i) && !wdog_clr_i) |=> !wdog_tmo_o); // R11

endmodule

bind cfg_update_ctrl cfgu_chk #(
    .OP_LAT   (OP_LAT),
    .RCFG_LAT (RCFG_LAT)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .rd_req_i     (rd_req_i),
    .wr_req_i     (wr_req_i),
    .reconf_req_i (reconf_req_i),
    .wdog_clr_i   (wdog_clr_i),
    .app_mode_i   (app_mode),
    .busy_o       (busy_o),
    .rdata_o      (rdata_o),
    .reconf_o     (reconf_o),
    .wdog_tmo_o   (wdog_tmo_o)
);

// File: tb/cfg_update_ctrl_tb.sv
`timescale 1ns/1ps
module cfg_update_ctrl_tb;

    localparam int OP_LAT   = 4;
    localparam int RCFG_LAT = 6;
    localparam int T        = 5;
    localparam int NVEC     = 14;

    // {is_write, sel, bank, data, expected read value}
    localparam logic [68:0] VEC [NVEC] = '{
        {1'b1, 3'd3, 1'b0, 32'hDEADBEEF, 32'h0},
        {1'b0, 3'd3, 1'b0, 32'h0,        32'hDEADBEEF},
        {1'b0, 3'd3, 1'b1, 32'h0,        32'h0},
        {1'b1, 3'd0, 1'b0, 32'hFFFFFFFF, 32'h0},
        {1'b0, 3'd0, 1'b0, 32'h0,        32'h0000001F},
        {1'b1, 3'd1, 1'b0, 32'hFFFFF123, 32'h0},
        {1'b0, 3'd1, 1'b0, 32'h0,        32'h00000123},
        {1'b1, 3'd6, 1'b0, 32'hA5A5A5A5, 32'h0},
        {1'b0, 3'd6, 1'b0, 32'h0,        32'h0},
        {1'b1, 3'd2, 1'b0, 32'hFFFFFFFE, 32'h0},
        {1'b0, 3'd2, 1'b0, 32'h0,        32'h0},
        {1'b1, 3'd2, 1'b0, 32'h00000001, 32'h0},
        {1'b1, 3'd1, 1'b0, 32'd5,        32'h0},
        {1'b0, 3'd1, 1'b0, 32'h0,        32'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd = 1'b0, wr = 1'b0, rcfg = 1'b0, clr = 1'b0, bank = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic        busy, reconf, tmo;
    logic [31:0] rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cfg_update_ctrl #(.OP_LAT(OP_LAT), .RCFG_LAT(RCFG_LAT)) u_dut (
        .clk_i(clk), .rst_i(rst), .rd_req_i(rd), .wr_req_i(wr), .sel_i(sel),
        .bank_ctl_i(bank), .wdata_i(wdata), .reconf_req_i(rcfg),
        .wdog_clr_i(clr), .busy_o(busy), .rdata_o(rdata),
        .reconf_o(reconf), .wdog_tmo_o(tmo)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input bit is_wr, input logic [2:0] s, input logic b,
                         input logic [31:0] d, output int n,
                         output logic [31:0] rv, output bit zb);
        @(negedge clk);
        sel = s; bank = b; wdata = d;
        if (is_wr) wr = 1'b1; else rd = 1'b1;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        n = 0; zb = 1'b1;
        while (busy && n < 50) begin
            n++;
            if (rdata != 32'd0) zb = 1'b0;
            @(negedge clk);
        end
        rv = rdata;
    endtask

    task automatic do_rcfg(output int n, output bit pulse);
        @(negedge clk);
        rcfg = 1'b1;
        @(negedge clk);
        rcfg = 1'b0;
        n = 0;
        while (busy && n < 50) begin
            n++;
            @(negedge clk);
        end
        pulse = reconf;
    endtask

    task automatic wait_tmo(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tmo && n < 100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        bit zb, pulse, seen;
        logic [31:0] rv;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && reconf == 1'b0 && tmo == 1'b0, "R1 flags in reset",
            {29'd0, busy, reconf, tmo}, 32'd0);
        chk(rdata == 32'd0, "R1 rdata in reset", rdata, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        do_op(1'b0, 3'd3, 1'b1, 32'd0, n, rv, zb);
        chk(rv == 32'd0, "R1 active page zero", rv, 32'd0);
        do_op(1'b0, 3'd4, 1'b0, 32'd0, n, rv, zb);
        chk(rv == 32'd0, "R1 staging mode zero", rv, 32'd0);

        // R2 R5 R6 vector table
        for (int i = 0; i < NVEC; i++) begin
            do_op(VEC[i][68], VEC[i][67:65], VEC[i][64], VEC[i][63:32], n, rv, zb);
            chk(n == OP_LAT, "R2 busy length", n, OP_LAT);
            chk(zb, "R3 rdata zero while busy", {31'd0, zb}, 32'd1);
            if (!VEC[i][68])
                chk(rv == VEC[i][31:0], "R6 R5 read value", rv, VEC[i][31:0]);
        end

        // R3 value held after read
        repeat (3) @(negedge clk);
        chk(rdata == 32'd5, "R3 read value held", rdata, 32'd5);

        // R2 held request
        @(negedge clk);
        sel = 3'd1; bank = 1'b0; rd = 1'b1;
        n = 0;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            if (busy) n++;
        end
        rd = 1'b0;
        chk(n == OP_LAT, "R2 held request runs once", n, OP_LAT);

        // R4 data changed during busy
        @(negedge clk);
        sel = 3'd3; wdata = 32'h11111111; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = 32'h22222222;
        while (busy) @(negedge clk);
        do_op(1'b0, 3'd3, 1'b0, 32'd0, n, rv, zb);
        chk(rv == 32'h11111111, "R4 wdata ignored while busy", rv, 32'h11111111);

        // R8 reconfiguration ignored while busy
        @(negedge clk);
        sel = 3'd0; wdata = 32'd3; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; rcfg = 1'b1; n = busy ? 1 : 0; seen = reconf;
        @(negedge clk);
        rcfg = 1'b0;
        for (int k = 0; k < OP_LAT + RCFG_LAT + 2; k++) begin
            if (busy) n++;
            if (reconf) seen = 1'b1;
            @(negedge clk);
        end
        chk(n == OP_LAT, "R8 busy only for write", n, OP_LAT);
        chk(!seen, "R8 reconf ignored while busy", {31'd0, seen}, 32'd0);

        // R8 R10 reconfiguration and watchdog start
        do_rcfg(n, pulse);
        chk(n == RCFG_LAT, "R8 reconf busy length", n, RCFG_LAT);
        chk(pulse, "R8 reconf pulse at busy fall", {31'd0, pulse}, 32'd1);
        wait_tmo(n);
        chk(n == T + 1, "R10 first timeout", n, T + 1);
        wait_tmo(n);
        chk(n == T + 1, "R10 timeout period", n, T + 1);

        // R11 clear during busy
        clr = 1'b1; sel = 3'd0; bank = 1'b1; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R11 busy while clearing", {31'd0, busy}, 32'd1);
        clr = 1'b0;
        wait_tmo(n);
        chk(n == T + 2, "R11 clear restarts counter", n, T + 2);

        // R11 clear and timeout in the same cycle
        clr = 1'b1;
        repeat (T) @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
        chk(tmo == 1'b0, "R11 clear beats timeout", {31'd0, tmo}, 32'd0);
        wait_tmo(n);
        chk(n == T + 1, "R11 period after collision", n, T + 1);

        // R5 active bank after reconfiguration
        do_op(1'b0, 3'd3, 1'b1, 32'd0, n, rv, zb);
        chk(rv == 32'h11111111, "R5 active page loaded", rv, 32'h11111111);
        do_op(1'b0, 3'd0, 1'b1, 32'd0, n, rv, zb);
        chk(rv == 32'd3, "R5 active status loaded", rv, 32'd3);

        // R9 reconfiguration and write together
        @(negedge clk);
        sel = 3'd3; wdata = 32'hCAFE0000; wr = 1'b1; rcfg = 1'b1;
        @(negedge clk);
        wr = 1'b0; rcfg = 1'b0; n = 0;
        while (busy && n < 50) begin
            n++;
            @(negedge clk);
        end
        chk(n == RCFG_LAT, "R9 reconf taken", n, RCFG_LAT);
        do_op(1'b0, 3'd3, 1'b0, 32'd0, n, rv, zb);
        chk(rv == 32'h11111111, "R9 write dropped", rv, 32'h11111111);

        // R7 application mode
        do_op(1'b1, 3'd4, 1'b0, 32'd1, n, rv, zb);
        do_rcfg(n, pulse);
        do_op(1'b0, 3'd4, 1'b1, 32'd0, n, rv, zb);
        chk(rv == 32'd1, "R7 active mode is application", rv, 32'd1);
        do_op(1'b1, 3'd3, 1'b0, 32'h99, n, rv, zb);
        chk(n == 0, "R7 write raises no busy", n, 0);
        do_op(1'b0, 3'd3, 1'b0, 32'd0, n, rv, zb);
        chk(rv == 32'h11111111, "R7 staging unchanged", rv, 32'h11111111);

        // R1 reset again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 idle after reset", {31'd0, busy}, 32'd0);
        do_op(1'b0, 3'd4, 1'b1, 32'd0, n, rv, zb);
        chk(rv == 32'd0, "R1 mode cleared by reset", rv, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule